// File: doc/BRIEF.md
# Wave launch scalar register initializer

When a compute wave is launched, this block turns a latched dispatch descriptor and a set of enable bits into an ordered stream of scalar register writes. The descriptor carries the private buffer resource (four words), five 64-bit values, the per-item scratch byte size, grid and workgroup sizes for three dimensions, the workgroup IDs, the fields of the info word and the per-wave scratch offset.

Every enabled field gets a densely packed register index in a fixed order. The user region holds at most `USER_LIMIT` registers (16 by default), and anything beyond that is dropped. The per-wave system registers follow directly after the user region. One write leaves the block per clock on a valid/index/data port. A one-cycle done pulse closes the stream, and at that point the block also reports the user register count and a flag for a workgroup size of zero.

Top module: `wave_sreg_init`

## Requirements
- R1: User words are issued in this slot order: private buffer (4 words, `priv_buf_i` bits 31:0 first), dispatch pointer (2), queue pointer (2), kernel argument pointer (2), dispatch ID (2), flat scratch init (2), private size (1), then the workgroup counts for X, Y and Z (1 each).
- R2: `user_en_i` bit k enables the k-th user field of R1, with bit 0 as the private buffer and bit 9 as the Z count. A cleared bit issues no word for that field.
- R3: Write indices start at 0 and increase by exactly 1 on each consecutive valid cycle, with no gaps for disabled fields.
- R4: No more than `USER_LIMIT` user words are written, and enabled words beyond that limit are dropped. At done, `user_cnt_o` equals min(requested user words, `USER_LIMIT`).
- R5: Each count word is ceil(grid/wg) for its dimension and must not overflow even for a grid size of 2^32-1. X sits in bits 31:0 of `grid_size_i` and `wg_size_i`, Y in 63:32 and Z in 95:64.
- R6: The private size word is `item_scratch_i` rounded up to a multiple of 4.
- R7: System words follow the user words in this order: workgroup ID X (always issued), ID Y, ID Z, info, wave offset. `sys_en_i` bit 0 enables Y, bit 1 Z, bit 2 info and bit 3 wave offset. The IDs are packed in `wg_id_i` in the same way as the grid sizes.
- R8: Enabling ID Z also issues ID Y, even when bit 0 of `sys_en_i` is clear.
- R9: The info word is {first_wave, 14 zero bits, ordered-append term[10:0], waves[5:0]}, with first_wave at bit 31.
- R10: Each 64-bit value takes two consecutive indices, with the low 32 bits at the lower index.
- R11: After reset all outputs are 0. A start sampled while idle latches the descriptor, and the first write appears one clock later. Done is high for exactly the one cycle after the last write. A start sampled while busy is ignored.
- R12: A workgroup size of zero in a dimension yields a count of 0 for that dimension and sets `div_err_o` at done. Otherwise `div_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Latch descriptor and begin a stream |
| user_en_i | input | 10 | User field enables (R2) |
| sys_en_i | input | 4 | System field enables (R7) |
| priv_buf_i | input | 128 | Private buffer resource words |
| dispatch_ptr_i | input | 64 | Dispatch packet address |
| queue_ptr_i | input | 64 | Queue object address |
| kernarg_ptr_i | input | 64 | Kernel argument address |
| dispatch_id_i | input | 64 | Dispatch identifier |
| flat_scratch_i | input | 64 | Flat scratch init value |
| item_scratch_i | input | 32 | Per-item scratch bytes |
| grid_size_i | input | 96 | Grid size X/Y/Z |
| wg_size_i | input | 96 | Workgroup size X/Y/Z |
| wg_id_i | input | 96 | Workgroup ID X/Y/Z |
| first_wave_i | input | 1 | Info bit 31 |
| oa_term_i | input | 11 | Ordered-append term |
| tg_waves_i | input | 6 | Threadgroup size in waves |
| wave_ofs_i | input | 32 | Per-wave scratch byte offset |
| wr_valid_o | output | 1 | Register write strobe |
| wr_idx_o | output | 5 | Register index |
| wr_data_o | output | 32 | Register value |
| done_o | output | 1 | Stream complete pulse |
| user_cnt_o | output | 5 | User registers written |
| div_err_o | output | 1 | Zero workgroup size seen |

## Verification
The bench builds the block with `USER_LIMIT` = 16. With that value, enabling every user field requests 18 words, so truncation is reachable: the two trailing counts are dropped and ID X lands at index 16. A second pattern that requests exactly 16 words checks the limit without any dropped words. The 32-bit word width makes a grid size of 2^32-1 a meaningful test of the ceiling division's carry.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
  localparam int WORD_W      = 32;
  localparam int USER_FIELDS = 10;
  localparam int USER_WORDS  = 18;
  localparam int SYS_SLOTS   = 5;
  localparam int ALL_SLOTS   = USER_WORDS + SYS_SLOTS;
  localparam int NUM_PTR     = 5;
  localparam int NUM_DIM     = 3;

  // slot bases; user slot order is behaviour (index packing)
  localparam int SLOT_PTR   = 4;
  localparam int SLOT_PSIZE = 14;
  localparam int SLOT_GCNT  = 15;
  localparam int SLOT_WGID  = USER_WORDS;
  localparam int SLOT_INFO  = USER_WORDS + 3;
  localparam int SLOT_WOFS  = USER_WORDS + 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  function automatic int field_words(input int f);
    return (f == 0) ? 4 : (f <= 5) ? 2 : 1;
  endfunction

  function automatic int field_of_word(input int w);
    int acc;
    int res;
    acc = 0;
    res = 0;
    for (int f = 0; f < USER_FIELDS; f++) begin
      if (w >= acc && w < acc + field_words(f)) res = f;
      acc += field_words(f);
    end
    return res;
  endfunction

  function automatic word_t pack_info(input logic first, input logic [10:0] term,
                                      input logic [5:0] waves);
    return {first, 14'd0, term, waves};
  endfunction
endpackage

// File: rtl/wsi_ceil_div.sv
module wsi_ceil_div #(
  parameter int W = 32
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic         zero_o
);
  logic [W:0] sum;
  logic [W:0] quo_wide;

  always_comb begin
    zero_o   = (den_i == '0);
    // one extra bit keeps num + den - 1 from wrapping
    sum      = {1'b0, num_i} + {1'b0, den_i} - (W+1)'(1);
    quo_wide = zero_o ? '0 : sum / {1'b0, den_i};
    quo_o    = W'(quo_wide);
  end
endmodule

// File: rtl/wsi_slot_map.sv
module wsi_slot_map
  import wsi_pkg::*;
#(
  parameter int USER_LIMIT = 16,
  parameter int IDX_W      = 5,
  parameter int CNT_W      = 5
) (
  input  logic [USER_FIELDS-1:0]          user_en_i,
  input  logic [SYS_SLOTS-2:0]            sys_en_i,
  output logic [ALL_SLOTS-1:0]            live_o,
  output logic [ALL_SLOTS-1:0][IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0]                user_cnt_o
);
  logic [USER_WORDS-1:0] word_req;
  logic [SYS_SLOTS-1:0]  sys_req;

  for (genvar w = 0; w < USER_WORDS; w++) begin : g_req
    localparam int FLD = field_of_word(w);
    assign word_req[w] = user_en_i[FLD];
  end

  // Z implies Y; X always present
  assign sys_req = {sys_en_i[3], sys_en_i[2], sys_en_i[1], sys_en_i[0] | sys_en_i[1], 1'b1};

  always_comb begin
    int run;
    run    = 0;
    live_o = '0;
    idx_o  = '0;
    for (int w = 0; w < USER_WORDS; w++) begin
      idx_o[w]  = IDX_W'(run);
      live_o[w] = word_req[w] && (run < USER_LIMIT);
      if (word_req[w]) run++;
    end
    if (run > USER_LIMIT) run = USER_LIMIT;
    user_cnt_o = CNT_W'(run);
    for (int s = 0; s < SYS_SLOTS; s++) begin
      idx_o[USER_WORDS+s]  = IDX_W'(run);
      live_o[USER_WORDS+s] = sys_req[s];
      if (sys_req[s]) run++;
    end
  end
endmodule

// File: rtl/wsi_pick.sv
module wsi_pick #(
  parameter int N     = 23,
  parameter int SEL_W = 5
) (
  input  logic [N-1:0]     live_i,
  input  logic [SEL_W-1:0] base_i,
  output logic             found_o,
  output logic [SEL_W-1:0] sel_o
);
  // lowest live slot at or above base
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    for (int s = N - 1; s >= 0; s--) begin
      if (live_i[s] && (SEL_W'(s) >= base_i)) begin
        found_o = 1'b1;
        sel_o   = SEL_W'(s);
      end
    end
  end
endmodule

// File: rtl/wave_sreg_init.sv
module wave_sreg_init
  import wsi_pkg::*;
#(
  parameter  int USER_LIMIT = 16,
  localparam int IDX_W      = $clog2(USER_LIMIT + SYS_SLOTS),
  localparam int CNT_W      = $clog2(USER_LIMIT + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [USER_FIELDS-1:0]    user_en_i,
  input  logic [SYS_SLOTS-2:0]      sys_en_i,
  input  logic [4*WORD_W-1:0]       priv_buf_i,
  input  logic [2*WORD_W-1:0]       dispatch_ptr_i,
  input  logic [2*WORD_W-1:0]       queue_ptr_i,
  input  logic [2*WORD_W-1:0]       kernarg_ptr_i,
  input  logic [2*WORD_W-1:0]       dispatch_id_i,
  input  logic [2*WORD_W-1:0]       flat_scratch_i,
  input  logic [WORD_W-1:0]         item_scratch_i,
  input  logic [NUM_DIM*WORD_W-1:0] grid_size_i,
  input  logic [NUM_DIM*WORD_W-1:0] wg_size_i,
  input  logic [NUM_DIM*WORD_W-1:0] wg_id_i,
  input  logic                      first_wave_i,
  input  logic [10:0]               oa_term_i,
  input  logic [5:0]                tg_waves_i,
  input  logic [WORD_W-1:0]         wave_ofs_i,
  output logic                      wr_valid_o,
  output logic [IDX_W-1:0]          wr_idx_o,
  output logic [WORD_W-1:0]         wr_data_o,
  output logic                      done_o,
  output logic [CNT_W-1:0]          user_cnt_o,
  output logic                      div_err_o
);
  localparam int BASE_W = $clog2(ALL_SLOTS + 1);

  seq_state_e                      state_q;
  logic [BASE_W-1:0]               base_q;
  logic [USER_FIELDS-1:0]          user_en_q;
  logic [SYS_SLOTS-2:0]            sys_en_q;
  logic [4*WORD_W-1:0]             priv_buf_q;
  logic [NUM_PTR-1:0][2*WORD_W-1:0] ptr_q;
  logic [WORD_W-1:0]               item_scratch_q;
  logic [NUM_DIM*WORD_W-1:0]       grid_q, wgsz_q, wgid_q;
  logic                            first_q;
  logic [10:0]                     term_q;
  logic [5:0]                      waves_q;
  logic [WORD_W-1:0]               wofs_q;

  logic [NUM_DIM-1:0][WORD_W-1:0]  wg_cnt;
  logic [NUM_DIM-1:0]              div_zero;
  logic [ALL_SLOTS-1:0]            slot_live;
  logic [ALL_SLOTS-1:0][IDX_W-1:0] slot_idx;
  logic [ALL_SLOTS-1:0][WORD_W-1:0] slot_data;
  logic [CNT_W-1:0]                map_cnt;
  logic                            pick_found;
  logic [BASE_W-1:0]               pick_sel;

  for (genvar d = 0; d < NUM_DIM; d++) begin : g_div
    wsi_ceil_div #(.W(WORD_W)) u_div (
      .num_i  (grid_q[d*WORD_W +: WORD_W]),
      .den_i  (wgsz_q[d*WORD_W +: WORD_W]),
      .quo_o  (wg_cnt[d]),
      .zero_o (div_zero[d])
    );
  end

  wsi_slot_map #(.USER_LIMIT(USER_LIMIT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_map (
    .user_en_i  (user_en_q),
    .sys_en_i   (sys_en_q),
    .live_o     (slot_live),
    .idx_o      (slot_idx),
    .user_cnt_o (map_cnt)
  );

  wsi_pick #(.N(ALL_SLOTS), .SEL_W(BASE_W)) u_pick (
    .live_i  (slot_live),
    .base_i  (base_q),
    .found_o (pick_found),
    .sel_o   (pick_sel)
  );

  always_comb begin
    for (int i = 0; i < SLOT_PTR; i++) slot_data[i] = priv_buf_q[i*WORD_W +: WORD_W];
    for (int p = 0; p < NUM_PTR; p++) begin
      slot_data[SLOT_PTR+2*p]   = ptr_q[p][WORD_W-1:0];
      slot_data[SLOT_PTR+2*p+1] = ptr_q[p][2*WORD_W-1:WORD_W];
    end
    slot_data[SLOT_PSIZE] = (item_scratch_q + WORD_W'(3)) & ~WORD_W'(3);
    for (int d = 0; d < NUM_DIM; d++) begin
      slot_data[SLOT_GCNT+d] = wg_cnt[d];
      slot_data[SLOT_WGID+d] = wgid_q[d*WORD_W +: WORD_W];
    end
    slot_data[SLOT_INFO] = pack_info(first_q, term_q, waves_q);
    slot_data[SLOT_WOFS] = wofs_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      base_q         <= '0;
      user_en_q      <= '0;
      sys_en_q       <= '0;
      priv_buf_q     <= '0;
      ptr_q          <= '0;
      item_scratch_q <= '0;
      grid_q         <= '0;
      wgsz_q         <= '0;
      wgid_q         <= '0;
      first_q        <= 1'b0;
      term_q         <= '0;
      waves_q        <= '0;
      wofs_q         <= '0;
      wr_valid_o     <= 1'b0;
      wr_idx_o       <= '0;
      wr_data_o      <= '0;
      done_o         <= 1'b0;
      user_cnt_o     <= '0;
      div_err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          wr_valid_o <= 1'b0;
          if (start_i) begin
            state_q        <= ST_RUN;
            base_q         <= '0;
            user_en_q      <= user_en_i;
            sys_en_q       <= sys_en_i;
            priv_buf_q     <= priv_buf_i;
            ptr_q          <= {flat_scratch_i, dispatch_id_i, kernarg_ptr_i,
                               queue_ptr_i, dispatch_ptr_i};
            item_scratch_q <= item_scratch_i;
            grid_q         <= grid_size_i;
            wgsz_q         <= wg_size_i;
            wgid_q         <= wg_id_i;
            first_q        <= first_wave_i;
            term_q         <= oa_term_i;
            waves_q        <= tg_waves_i;
            wofs_q         <= wave_ofs_i;
          end
        end
        ST_RUN: begin
          if (pick_found) begin
            wr_valid_o <= 1'b1;
            wr_idx_o   <= slot_idx[pick_sel];
            wr_data_o  <= slot_data[pick_sel];
            base_q     <= pick_sel + BASE_W'(1);
          end else begin
            wr_valid_o <= 1'b0;
            done_o     <= 1'b1;
            user_cnt_o <= map_cnt;
            div_err_o  <= |div_zero;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wsi_checker.sv
module wsi_checker
  import wsi_pkg::*;
#(
  parameter int USER_LIMIT = 16,
  parameter int IDX_W      = 5,
  parameter int CNT_W      = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic             done_i,
  input logic [CNT_W-1:0] user_cnt_i
);
  AST_IDX_FIRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !$past(wr_valid_i)) |-> (wr_idx_i == '0)); // R3
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && $past(wr_valid_i)) |-> (wr_idx_i == IDX_W'($past(wr_idx_i) + 1'b1))); // R3
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> (int'(wr_idx_i) < USER_LIMIT + SYS_SLOTS)); // R3
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(wr_valid_i) && !wr_valid_i)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R11
  AST_USER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (int'(user_cnt_i) <= USER_LIMIT)); // R4
endmodule

bind wave_sreg_init wsi_checker #(
  .USER_LIMIT (USER_LIMIT),
  .IDX_W      (IDX_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_o),
  .wr_idx_i   (wr_idx_o),
  .done_i     (done_o),
  .user_cnt_i (user_cnt_o)
);

// File: tb/sim_wave_sreg_init.sv
`timescale 1ns/1ps
module sim_wave_sreg_init;
  localparam int UL    = 16;
  localparam int IDX_W = $clog2(UL + 5);
  localparam int CNT_W = $clog2(UL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [9:0]   user_en = '0;
  logic [3:0]   sys_en = '0;
  logic [127:0] priv_buf;
  logic [63:0]  dptr, qptr, kptr, did, fscr;
  logic [31:0]  item_b;
  logic [95:0]  grid, wgsz, wgid;
  logic         first_w;
  logic [10:0]  term;
  logic [5:0]   waves;
  logic [31:0]  wofs;
  logic             wr_valid_o;
  logic [IDX_W-1:0] wr_idx_o;
  logic [31:0]      wr_data_o;
  logic             done_o;
  logic [CNT_W-1:0] user_cnt_o;
  logic             div_err_o;

  always #2 clk = ~clk;

  wave_sreg_init #(.USER_LIMIT(UL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .user_en_i(user_en), .sys_en_i(sys_en),
    .priv_buf_i(priv_buf), .dispatch_ptr_i(dptr), .queue_ptr_i(qptr), .kernarg_ptr_i(kptr),
    .dispatch_id_i(did), .flat_scratch_i(fscr), .item_scratch_i(item_b), .grid_size_i(grid),
    .wg_size_i(wgsz), .wg_id_i(wgid), .first_wave_i(first_w), .oa_term_i(term),
    .tg_waves_i(waves), .wave_ofs_i(wofs), .wr_valid_o(wr_valid_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o), .done_o(done_o), .user_cnt_o(user_cnt_o), .div_err_o(div_err_o)
  );

  typedef struct {
    int          idx;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t  exp_q[$];
  int    checks = 0;
  int    fails = 0;
  int    exp_cnt = 0;
  logic  exp_err = 1'b0;
  string case_name = "reset";
  bit    done_seen = 1'b0;
  logic  prev_valid = 1'b0;
  logic  prev_done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", tag, case_name, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ceil_cnt(input logic [31:0] g, input logic [31:0] w);
    if (w == 0) return 32'd0;
    return 32'((64'(g) + 64'(w) - 64'd1) / 64'(w));
  endfunction

  function automatic logic [31:0] user_word(input int f, input int k);
    logic [63:0] p;
    case (f)
      1: p = dptr;
      2: p = qptr;
      3: p = kptr;
      4: p = did;
      default: p = fscr;
    endcase
    if (f == 0) return priv_buf[32*k +: 32];
    if (f <= 5) return (k == 0) ? p[31:0] : p[63:32];
    if (f == 6) return (item_b + 32'd3) & ~32'd3;
    return ceil_cnt(grid[32*(f-7) +: 32], wgsz[32*(f-7) +: 32]);
  endfunction

  task automatic push(input int idx, input logic [31:0] d, input string tag);
    exp_t e;
    e.idx = idx;
    e.data = d;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // driver-side model: expected writes from the requirements
  task automatic build_expected();
    int fw[10] = '{4, 2, 2, 2, 2, 2, 1, 1, 1, 1};
    int run = 0;
    string tg;
    exp_q.delete();
    for (int f = 0; f < 10; f++) begin
      if (user_en[f]) begin
        for (int k = 0; k < fw[f]; k++) begin
          if (f == 0) tg = "R1";
          else if (f <= 5) tg = "R10";
          else if (f == 6) tg = "R6";
          else tg = (wgsz[32*(f-7) +: 32] == 0) ? "R12" : "R5";
          if (run < UL) push(run, user_word(f, k), tg);
          run++;
        end
      end
    end
    exp_cnt = (run > UL) ? UL : run;
    run = exp_cnt;
    push(run, wgid[31:0], "R7"); run++;
    if (sys_en[0] | sys_en[1]) begin
      push(run, wgid[63:32], sys_en[0] ? "R7" : "R8"); run++;
    end
    if (sys_en[1]) begin push(run, wgid[95:64], "R7"); run++; end
    if (sys_en[2]) begin push(run, {first_w, 14'd0, term, waves}, "R9"); run++; end
    if (sys_en[3]) begin push(run, wofs, "R7"); run++; end
    exp_err = (wgsz[31:0] == 0) || (wgsz[63:32] == 0) || (wgsz[95:64] == 0);
  endtask

  // monitor: pops and compares
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (wr_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected write", longint'(wr_idx_o), -1);
        end else begin
          e = exp_q.pop_front();
          check(int'(wr_idx_o) == e.idx, e.tag, "index", longint'(wr_idx_o), longint'(e.idx));
          check(wr_data_o == e.data, e.tag, "data", longint'(wr_data_o), longint'(e.data));
        end
      end
      if (prev_done) check(!done_o, "R11", "done longer than one cycle", done_o, 0);
      if (done_o) begin
        check(prev_valid, "R11", "done without preceding write", prev_valid, 1);
        check(exp_q.size() == 0, "R1", "writes missing at done", exp_q.size(), 0);
        check(int'(user_cnt_o) == exp_cnt, "R4", "user count", longint'(user_cnt_o), longint'(exp_cnt));
        check(div_err_o == exp_err, "R12", "error flag", div_err_o, exp_err);
        done_seen = 1'b1;
      end
      prev_valid = wr_valid_o;
      prev_done  = done_o;
    end
  end

  task automatic run_case(input string name, input bit busy_poke);
    case_name = name;
    build_expected();
    done_seen = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!wr_valid_o, "R11", "write before latency", wr_valid_o, 0);
    if (busy_poke) begin
      start = 1'b1;
      user_en = '1;
      sys_en = '1;
    end
    @(negedge clk);
    start = 1'b0;
    check(wr_valid_o, "R11", "first write one cycle after start", wr_valid_o, 1);
    while (!done_seen) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_defaults();
    priv_buf = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    dptr = 64'hD1D1_0002_D1D1_0001;
    qptr = 64'hE2E2_0002_E2E2_0001;
    kptr = 64'hF3F3_0002_F3F3_0001;
    did  = 64'hA4A4_0002_A4A4_0001;
    fscr = 64'hB5B5_0002_B5B5_0001;
    item_b = 32'd13;
    grid = {32'd9, 32'd50, 32'd100};
    wgsz = {32'd3, 32'd8, 32'd7};
    wgid = {32'h0000_0005, 32'h0000_0006, 32'h0000_0007};
    first_w = 1'b1;
    term = 11'h5A5;
    waves = 6'h2B;
    wofs = 32'h0000_8000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_defaults();
    repeat (4) @(negedge clk);
    check(!wr_valid_o && !done_o, "R11", "reset strobes", {wr_valid_o, done_o}, 0);
    check(user_cnt_o == 0 && !div_err_o, "R11", "reset status", {user_cnt_o, div_err_o}, 0);
    check(wr_idx_o == 0 && wr_data_o == 0, "R11", "reset data", wr_data_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    user_en = '0; sys_en = '0;
    run_case("R7 only ID X", 1'b0);

    for (int f = 0; f < 10; f++) begin
      user_en = 10'(1) << f; sys_en = '0;
      run_case($sformatf("R2 single field bit %0d", f), 1'b0);
    end

    user_en = '1; sys_en = 4'b0000;
    run_case("R4 all user fields truncated", 1'b0);

    user_en = 10'b00_0111_1111 | 10'b00_1000_0000; sys_en = 4'b1111;
    run_case("R4 exactly limit plus all system", 1'b0);

    user_en = 10'b00_1100_1010; sys_en = 4'b0010;
    run_case("R3 R8 sparse fields, Z forces Y", 1'b0);

    user_en = 10'b00_0000_0100; sys_en = 4'b0101;
    run_case("R9 info word and Y", 1'b0);

    user_en = 10'b11_1000_0000; sys_en = 4'b0000;
    grid = {32'd1, 32'd0, 32'd64}; wgsz = {32'd1, 32'd4, 32'd64};
    run_case("R5 exact, zero grid, unit", 1'b0);

    grid = {32'hFFFF_FFFF, 32'd17, 32'hFFFF_FFFF}; wgsz = {32'd1, 32'd16, 32'd2};
    run_case("R5 wide grid no overflow", 1'b0);

    grid = {32'd9, 32'd50, 32'd100}; wgsz = {32'd3, 32'd0, 32'd7};
    run_case("R12 zero workgroup size", 1'b0);

    set_defaults();
    item_b = 32'd16; user_en = 10'b00_0100_0000; sys_en = 4'b1000;
    run_case("R6 aligned size kept", 1'b0);
    item_b = 32'd1;
    run_case("R6 size 1 rounds to 4", 1'b0);

    user_en = 10'b00_0000_0011; sys_en = 4'b0100;
    run_case("R11 start while busy ignored", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule